// File: doc/BRIEF.md
# Timed Pin-Pattern Player

The block replays a ring of precomputed output patterns with exact timing. A producer loads entries, each a 12-bit pin pattern plus an 8-bit hold count. The player puts each pattern on twelve output pins and holds it for the stored number of update ticks. It then moves on to the next entry.

An external tick-enable marks the update instants, so the player runs from any system clock. For example, it can tick once per microsecond while the core runs much faster. This lets a slow producer prepare a burst of tightly spaced edges ahead of time, while the player keeps the output timing exact.

The ring has 64 slots, addressed by 6-bit pointers that wrap by overflow. One slot stays empty to tell full from empty, so 63 entries can be pending at once.

Top module: `pattern_player`

## Requirements
- R1: While rst_ni is low, pins_o is 0, full_o is 0 and underrun_o is 0.
- R2: A write (wr_en_i high at a clock edge while full_o is low) appends {wr_dly_i, wr_pins_i} to the ring. full_o is high exactly when 63 entries are pending.
- R3: A write presented while full_o is high is dropped. That entry never appears on pins_o, and the following entries still play in their original order.
- R4: At a clock edge where tick_i is high, the hold of the current entry has run out, and an entry is pending, pins_o takes that entry's pattern from the next cycle on. Bit i of the pattern drives pins_o[i].
- R5: An entry loaded with hold count D ≥ 1 stays on pins_o for exactly D ticks. The next update happens on the D-th tick after the loading tick. Cycles with tick_i low do not count, and pins_o changes only at ticks.
- R6: A hold count of 0 behaves exactly like a hold count of 1.
- R7: Read and write positions wrap from slot 63 to slot 0 with no gap. Playback order across the wrap equals write order.
- R8: If playback has started and an update tick finds no entry pending, pins_o keeps its last pattern and underrun_o goes high. underrun_o then stays high until reset. Playback resumes on the first update tick after a new entry arrives.
- R9: Before the first entry has ever been loaded, update ticks with an empty ring do not raise underrun_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Update tick enable, one clock wide per tick |
| wr_en_i | input | 1 | Producer write strobe |
| wr_pins_i | input | 12 | Pin pattern of the entry being written |
| wr_dly_i | input | 8 | Hold count of the entry, in ticks |
| full_o | output | 1 | Ring holds 63 pending entries |
| pins_o | output | 12 | Current output pattern |
| underrun_o | output | 1 | Sticky flag: playback ran dry |

## Verification
The bench targets these corner cases:
- **Zero hold count.** A design that treats 0 as 256 would stall, and one that never loads the counter would play the next entry on the same tick.
- **Ticks spaced several cycles apart.** A counter that decrements on every clock would cut holds short.
- **Filling past capacity without ticks.** A design that accepts a write while full would overwrite unread data, or make the ring look empty.
- **Playback across the pointer wrap.** An off-by-one here would reorder or repeat patterns.
- **Empty ring before and after playback starts.** A design without the start qualifier would flag underrun at power-up. One that clears the flag would lose it after the refill that resumes playback.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned PinsDef  = 12;
  localparam int unsigned DepthDef = 64;
  localparam int unsigned DlyWDef  = 8;

  // hold count 0 is treated as 1; returns ticks left after the loading tick
  function automatic logic [DlyWDef-1:0] hold_remaining(input logic [DlyWDef-1:0] dly);
    return (dly == '0) ? '0 : dly - 1'b1;
  endfunction
endpackage

// File: rtl/pp_ring.sv
module pp_ring #(
  parameter int unsigned W     = 20,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_i,
  output logic [W-1:0] rd_data_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_ok, rd_ok;

  // one slot kept free to tell full from empty
  assign full_o    = (AW'(wr_ptr + 1'b1) == rd_ptr);
  assign empty_o   = (wr_ptr == rd_ptr);
  assign wr_ok     = wr_i & ~full_o;
  assign rd_ok     = rd_i & ~empty_o;
  assign rd_data_o = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wr_ptr] <= wr_data_i;
  end

  // pointers wrap by overflow, DEPTH must be a power of two
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // R2
  no_full_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  // R3
  wr_full_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o) |=> $stable(wr_ptr));
  // R7
  rd_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !empty_o) |=> (rd_ptr == AW'($past(rd_ptr) + 1'b1)));
  // R8
  rd_empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o && !wr_i) |=> $stable(rd_ptr));
endmodule

// File: rtl/pp_timer.sv
module pp_timer
  import pp_pkg::*;
#(
  parameter int unsigned DW = DlyWDef
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] dly_i,
  output logic          expired_o
);
  logic [DW-1:0] cnt;

  assign expired_o = (cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt <= '0;
    else if (load_i)              cnt <= (dly_i == '0) ? '0 : dly_i - 1'b1;
    else if (tick_i && !expired_o) cnt <= cnt - 1'b1;
  end

  // R5
  tick_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt));
  // R6
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && dly_i <= DW'(1)) |=> expired_o);
endmodule

// File: rtl/pattern_player.sv
module pattern_player
  import pp_pkg::*;
#(
  parameter int unsigned PINS  = PinsDef,
  parameter int unsigned DEPTH = DepthDef,
  parameter int unsigned DLY_W = DlyWDef,
  localparam int unsigned EW   = PINS + DLY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [PINS-1:0]  wr_pins_i,
  input  logic [DLY_W-1:0] wr_dly_i,
  output logic             full_o,
  output logic [PINS-1:0]  pins_o,
  output logic             underrun_o
);
  logic [EW-1:0] head;
  logic          empty, expired, upd, pop, started;

  pp_ring #(.W(EW), .DEPTH(DEPTH)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en_i),
    .wr_data_i ({wr_dly_i, wr_pins_i}),
    .rd_i      (upd),
    .rd_data_o (head),
    .full_o    (full_o),
    .empty_o   (empty)
  );

  assign upd = tick_i & expired;
  assign pop = upd & ~empty;

  pp_timer #(.DW(DLY_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .load_i    (pop),
    .dly_i     (head[EW-1:PINS]),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_o     <= '0;
      started    <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      if (pop) begin
        pins_o  <= head[PINS-1:0];
        started <= 1'b1;
      end
      if (upd && empty && started) underrun_o <= 1'b1;
    end
  end

  // R5
  pins_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pins_o));
  // R8
  underrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);
  // R9
  no_early_underrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started |-> !underrun_o);
endmodule

// File: tb/pattern_player_bench.sv
module pattern_player_bench;
  localparam int PINS = 12, DLY_W = 8, CAP = 63;

  logic clk = 0, rst_n = 0, tick = 0, wr = 0;
  logic [PINS-1:0]  wpins = '0;
  logic [DLY_W-1:0] wdly = '0;
  logic             full, underrun;
  logic [PINS-1:0]  pins;

  pattern_player u_pattern_player (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr),
    .wr_pins_i(wpins), .wr_dly_i(wdly),
    .full_o(full), .pins_o(pins), .underrun_o(underrun));

  always #4 clk = ~clk;

  // behavioural reference
  logic [19:0] q[$];
  int m_cnt = 0;
  bit m_started = 0, m_und = 0;
  logic [PINS-1:0] m_pins = '0;
  int n_vec = 0, n_bad = 0, cycles = 0;
  string req = "R1";
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_cnt = 0; m_started = 0; m_und = 0; m_pins = '0;
    end else begin
      bit was_empty, was_full;
      logic [19:0] e;
      was_empty = (q.size() == 0);
      was_full  = (q.size() == CAP);
      if (tick) begin
        if (m_cnt == 0) begin
          if (!was_empty) begin
            e = q.pop_front();
            m_pins = e[11:0];
            m_cnt = (e[19:12] == 0) ? 0 : int'(e[19:12]) - 1;
            m_started = 1;
          end else if (m_started) m_und = 1;
        end else m_cnt--;
      end
      if (wr && !was_full) q.push_back({wdly, wpins});
    end
  end

  always @(negedge clk) if (!done) begin
    n_vec++;
    if (pins !== m_pins) begin
      n_bad++; $display("FAIL %s pins_o got %h exp %h", req, pins, m_pins);
    end
    if (full !== (q.size() == CAP)) begin
      n_bad++; $display("FAIL %s full_o got %b exp %b", req, full, q.size() == CAP);
    end
    if (underrun !== m_und) begin
      n_bad++; $display("FAIL %s underrun_o got %b exp %b", req, underrun, m_und);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_bad++; done = 1;
      $display("FAIL watchdog got %0d cycles exp completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic drive(input bit t, input bit w, input logic [11:0] p, input logic [7:0] d);
    @(negedge clk); #1;
    tick = t; wr = w; wpins = p; wdly = d;
  endtask

  initial begin
    // R1: reset state compared by the model every cycle
    repeat (3) drive(0, 0, 0, 0);
    rst_n = 1;
    // R9: ticks on an empty ring before any entry
    req = "R9";
    repeat (5) drive(1, 0, 0, 0);
    // R4 R6: entries with holds 3, 0, 2
    req = "R4/R6";
    drive(0, 1, 12'hA5C, 8'd3);
    drive(0, 1, 12'h3F0, 8'd0);
    drive(0, 1, 12'hFFF, 8'd2);
    repeat (10) drive(1, 0, 0, 0);
    // R8: underrun flagged, then resume with new entry, flag stays
    req = "R8";
    repeat (3) drive(1, 0, 0, 0);
    drive(1, 1, 12'h001, 8'd1);
    repeat (6) drive(1, 0, 0, 0);
    // R5: sparse ticks, every third cycle
    req = "R5";
    for (int i = 0; i < 4; i++) drive(0, 1, 12'(i * 12'h111 + 12'h00F), 8'(i + 2));
    for (int i = 0; i < 60; i++) drive(i % 3 == 0, 0, 0, 0);
    // R2 R3 R7: overfill with no ticks, then drain across the wrap
    req = "R2/R3/R7";
    for (int i = 0; i < 70; i++) drive(0, 1, 12'(i * 37 + 5), 8'(i % 3));
    repeat (4) drive(0, 0, 0, 0);
    for (int i = 0; i < 90; i++) drive(1, (i % 5 == 0), 12'(i + 12'h800), 8'd1);
    // R8: reset clears the sticky flag, R1 values return
    req = "R8/R1";
    @(negedge clk); #1; rst_n = 0; tick = 0; wr = 0;
    repeat (3) drive(0, 0, 0, 0);
    rst_n = 1;
    repeat (4) drive(1, 0, 0, 0);
    @(negedge clk); #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule